// File: doc/BRIEF.md
# Selectable Interrupt Source Controller

This block raises a single level-sensitive interrupt request toward a host. The request comes from one source at a time, picked by a 3-bit code. The candidates are four port bits (two of them inverted), the output of an external timer, and a software trigger. A shared polarity bit decides whether rising or falling transitions of the chosen signal count as events. A detected event sets a sticky pending flag, and only a host clear strobe or reset removes it.

The host reaches the block through a byte-wide write port with three offsets:
- a select register at offset 0xA, which holds the source code, the polarity bit and a 2-bit reference clock choice;
- a trigger strobe at offset 8;
- a clear strobe at offset 9.

The data byte of a strobe write is ignored. The 2-bit clock choice is driven out as a mux select for the external timer's reference clock: 00 selects 32.768 kHz, 01 selects 0.5 MHz, 10 selects 1 MHz and 11 selects 2 MHz.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset the select register holds 0x07, `irq` is 0 and `clk_sel` is 00.
- R2: A write to offset 0xA loads the select register. Bits 2:0 are the source code, bit 3 is the polarity and bits 5:4 drive `clk_sel` from the following cycle. Bits 7:6 have no effect.
- R3: The source codes are: 0 = `g0_portc[0]`, 1 = `timer_out`, 2 = `g0_portc[3]`, 3 = NOT `g0_portc[7]`, 4 = `g1_portc[3]`, 5 = NOT `g1_portc[7]`.
- R4: With polarity 1, only 0-to-1 transitions of the selected (possibly inverted) level are events. With polarity 0, only 1-to-0 transitions are events.
- R5: External inputs pass through a two-flop synchronizer. An input change made before clock edge A sets `irq` at edge A+2 and not earlier.
- R6: Once set, `irq` stays high until a write of any data to offset 9 clears it.
- R7: When a clear write and a new event fall in the same cycle, `irq` stays set.
- R8: With source code 6 selected, a write of any data to offset 8 sets `irq` at the edge of that write, whatever the polarity bit.
- R9: A write to offset 8 has no effect under any source code other than 6.
- R10: Source code 7 disables interrupts, so no input activity sets `irq`.
- R11: Changing the source code raises no interrupt, even when the newly selected level differs from the old one.
- R12: Writes to any other offset leave the select register and `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 4 | Host write offset |
| wr_data | input | 8 | Host write data |
| g0_portc | input | 8 | Port C bits of I/O group 0 |
| g1_portc | input | 8 | Port C bits of I/O group 1 |
| timer_out | input | 1 | Output of the external timer |
| irq | output | 1 | Level interrupt request (pending flag) |
| clk_sel | output | 2 | Reference clock choice for the timer |

## Verification
Each of the six hardware sources is selected in turn. Its raw input is then driven so that the effective level rises. This check tells apart a wrong source mapping from a missing inversion on codes 3 and 5. Both polarities are tried against both transition directions, so a swapped polarity bit shows up. Other patterns are:
- a transition sampled one cycle early and then on time, which exposes a wrong synchronizer depth;
- a select change onto a differing level, which checks the re-seed;
- a clear landing in the event cycle, which checks the priority of a new event over a clear;
- trigger writes under codes 6, 2 and 7, which separate a gated trigger from an ungated one.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int N_EXT    = 6;

    localparam logic [ADDR_W-1:0] OFF_TRIG = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_CLR  = 4'h9;
    localparam logic [ADDR_W-1:0] OFF_SEL  = 4'hA;

    typedef enum logic [2:0] {
        SRC_G0_B0   = 3'd0,
        SRC_TIMER   = 3'd1,
        SRC_G0_B3   = 3'd2,
        SRC_G0_NB7  = 3'd3,
        SRC_G1_B3   = 3'd4,
        SRC_G1_NB7  = 3'd5,
        SRC_SOFT    = 3'd6,
        SRC_OFF     = 3'd7
    } src_e;

    typedef enum logic [1:0] {
        CK_32K  = 2'd0,
        CK_500K = 2'd1,
        CK_1M   = 2'd2,
        CK_2M   = 2'd3
    } clk_e;

    typedef struct packed {
        logic [1:0] spare;
        clk_e       clk;
        logic       rise;
        src_e       src;
    } sel_reg_t;

    localparam sel_reg_t SEL_RESET = sel_reg_t'(8'h07);

    // Effective level of a hardware source from the synchronized input vector.
    // Vector order: {g1_b7, g1_b3, g0_b7, g0_b3, timer, g0_b0}
    function automatic logic src_level(input src_e s, input logic [N_EXT-1:0] v);
        case (s)
            SRC_G0_B0:  return v[0];
            SRC_TIMER:  return v[1];
            SRC_G0_B3:  return v[2];
            SRC_G0_NB7: return ~v[3];
            SRC_G1_B3:  return v[4];
            SRC_G1_NB7: return ~v[5];
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic src_is_hw(input src_e s);
        return (s != SRC_SOFT) && (s != SRC_OFF);
    endfunction

endpackage

// File: rtl/irq_host_regs.sv
module irq_host_regs
    import irq_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output sel_reg_t          sel,
    output logic              trig_stb,
    output logic              clr_stb
);

    always_ff @(posedge clk) begin
        if (rst)
            sel <= SEL_RESET;
        else if (wr_en && wr_addr == OFF_SEL)
            sel <= sel_reg_t'(wr_data);
    end

    always_comb begin
        trig_stb = wr_en && (wr_addr == OFF_TRIG);
        clr_stb  = wr_en && (wr_addr == OFF_CLR);
    end

    // R1: select register comes out of reset disabled
    a_r1_reset_sel: assert property (@(posedge clk)
        $past(rst) && !rst |-> sel == SEL_RESET);

    // R12: writes elsewhere leave the select register alone
    a_r12_other_offsets: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !(wr_en && wr_addr == OFF_SEL)) |-> $stable(sel));

endmodule

// File: rtl/irq_src_mux.sv
module irq_src_mux
    import irq_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EXT-1:0] raw_in,
    input  src_e             src,
    output logic             level
);

    logic [N_EXT-1:0] stage [SYNC_STAGES];

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst)
                stage[i] <= '0;
            else if (i == 0)
                stage[i] <= raw_in;
            else
                stage[i] <= stage[(i == 0) ? 0 : i-1];
        end
    end

    always_comb level = src_level(src, stage[SYNC_STAGES-1]);

endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch
    import irq_sel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  src_e src,
    input  logic rise,
    input  logic level,
    input  logic trig_stb,
    input  logic clr_stb,
    output logic pending
);

    src_e src_q;
    logic prev;
    logic src_chg;
    logic edge_hit;
    logic sw_hit;

    always_comb begin
        src_chg  = (src != src_q);
        edge_hit = src_is_hw(src) && !src_chg &&
                   (rise ? (level && !prev) : (!level && prev));
        sw_hit   = trig_stb && (src == SRC_SOFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= SRC_OFF;
            prev    <= 1'b0;
            pending <= 1'b0;
        end else begin
            src_q   <= src;
            prev    <= level;
            pending <= edge_hit || sw_hit || (pending && !clr_stb);
        end
    end

    // R6: pending only rises from an event or software trigger
    a_r6_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(edge_hit || sw_hit));

    // R6: a lone clear empties the flag
    a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
        clr_stb && !edge_hit && !sw_hit |=> !pending);

    // R7: an event in the clear cycle wins
    a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
        clr_stb && edge_hit |=> pending);

    // R10: disabled selection never raises the flag
    a_r10_disabled: assert property (@(posedge clk) disable iff (rst)
        src == SRC_OFF && !pending |=> !pending);

    // R11: a select change raises nothing in the cycle it is seen
    a_r11_reseed: assert property (@(posedge clk) disable iff (rst)
        src_chg && !trig_stb |=> !$rose(pending));

endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
    import irq_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [7:0]        g0_portc,
    input  logic [7:0]        g1_portc,
    input  logic              timer_out,
    output logic              irq,
    output logic [1:0]        clk_sel
);

    sel_reg_t         sel;
    logic             trig_stb;
    logic             clr_stb;
    logic             level;
    logic [N_EXT-1:0] raw_in;

    always_comb raw_in = {g1_portc[7], g1_portc[3], g0_portc[7],
                          g0_portc[3], timer_out, g0_portc[0]};

    irq_host_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sel      (sel),
        .trig_stb (trig_stb),
        .clr_stb  (clr_stb)
    );

    irq_src_mux #(.SYNC_STAGES(2)) u_mux (
        .clk    (clk),
        .rst    (rst),
        .raw_in (raw_in),
        .src    (sel.src),
        .level  (level)
    );

    irq_edge_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .src      (sel.src),
        .rise     (sel.rise),
        .level    (level),
        .trig_stb (trig_stb),
        .clr_stb  (clr_stb),
        .pending  (irq)
    );

    always_comb clk_sel = sel.clk;

    // R8: trigger under software selection sets irq on the write edge
    a_r8_soft_trig: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr == OFF_TRIG && sel.src == SRC_SOFT |=> irq);

endmodule

// File: tb/tb_irq_source_ctrl.sv
module tb_irq_source_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] g0_portc;
    logic [7:0] g1_portc;
    logic       timer_out;
    logic       irq;
    logic [1:0] clk_sel;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    irq_source_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .g0_portc(g0_portc), .g1_portc(g1_portc),
        .timer_out(timer_out), .irq(irq), .clk_sel(clk_sel)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // raw input for a source code, value as seen on the pin
    task automatic drive_src(input int s, input logic v);
        case (s)
            0: g0_portc[0] = v;
            1: timer_out   = v;
            2: g0_portc[3] = v;
            3: g0_portc[7] = v;
            4: g1_portc[3] = v;
            default: g1_portc[7] = v;
        endcase
    endtask

    task automatic t_reset;
        check("R1 irq", irq, 0);
        check("R1 clk_sel", clk_sel, 0);
        drive_src(0, 1'b1); idle(5);
        check("R1 disabled after reset", irq, 0);
        drive_src(0, 1'b0); idle(3);
    endtask

    // each hardware source, rising polarity, effective 0 -> 1
    task automatic t_source(input int s);
        logic inv;
        inv = (s == 3 || s == 5);
        drive_src(s, inv);
        wr(4'hA, 8'h08 | 8'(s));
        idle(4);
        wr(4'h9, 8'h00);
        check($sformatf("R3 src%0d quiet", s), irq, 0);
        @(negedge clk);
        drive_src(s, !inv);
        idle(3);
        check($sformatf("R3 src%0d fires", s), irq, 1);
        idle(3);
        check($sformatf("R6 src%0d sticky", s), irq, 1);
        wr(4'h9, 8'h5A);
        check($sformatf("R6 src%0d cleared", s), irq, 0);
        drive_src(s, inv); idle(4);
        wr(4'h9, 8'h00);
    endtask

    task automatic t_polarity;
        drive_src(2, 1'b1);
        wr(4'hA, 8'h0A); idle(4); wr(4'h9, 0);
        drive_src(2, 1'b0); idle(4);
        check("R4 rising ignores fall", irq, 0);
        wr(4'hA, 8'h02); idle(4); wr(4'h9, 0);
        drive_src(2, 1'b1); idle(4);
        check("R4 falling ignores rise", irq, 0);
        @(negedge clk);
        drive_src(2, 1'b0); idle(3);
        check("R4 falling fires", irq, 1);
        wr(4'h9, 0);
    endtask

    task automatic t_sync_latency;
        drive_src(4, 1'b0);
        wr(4'hA, 8'h0C); idle(4); wr(4'h9, 0);
        @(negedge clk);
        drive_src(4, 1'b1);
        idle(2);
        check("R5 not yet at A+1", irq, 0);
        @(negedge clk);
        check("R5 set at A+2", irq, 1);
        wr(4'h9, 0);
        drive_src(4, 1'b0); idle(4); wr(4'h9, 0);
    endtask

    task automatic t_clear_race;
        drive_src(0, 1'b0);
        wr(4'hA, 8'h08); idle(4); wr(4'h9, 0);
        @(negedge clk);
        drive_src(0, 1'b1);
        idle(2);
        wr_en = 1'b1; wr_addr = 4'h9; wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        check("R7 event beats clear", irq, 1);
        wr(4'h9, 0);
        check("R7 later clear", irq, 0);
        drive_src(0, 1'b0); idle(4); wr(4'h9, 0);
    endtask

    task automatic t_soft;
        wr(4'hA, 8'h06);
        idle(2);
        wr(4'h8, 8'h00);
        check("R8 trig falling polarity", irq, 1);
        wr(4'h9, 0);
        wr(4'hA, 8'h0E);
        wr(4'h8, 8'hC3);
        check("R8 trig rising polarity", irq, 1);
        wr(4'h9, 0);
        wr(4'hA, 8'h0A); idle(4); wr(4'h9, 0);
        wr(4'h8, 8'hFF); idle(2);
        check("R9 trig ignored src2", irq, 0);
        wr(4'hA, 8'h07);
        wr(4'h8, 8'hFF); idle(2);
        check("R9 trig ignored src7", irq, 0);
    endtask

    task automatic t_disabled;
        wr(4'hA, 8'h0F);
        g0_portc = 8'hFF; g1_portc = 8'hFF; timer_out = 1'b1; idle(4);
        g0_portc = 8'h00; g1_portc = 8'h00; timer_out = 1'b0; idle(4);
        check("R10 disabled", irq, 0);
    endtask

    task automatic t_reseed;
        g0_portc[7] = 1'b0;
        wr(4'hA, 8'h07); idle(4);
        wr(4'hA, 8'h0B);
        idle(4);
        check("R11 switch to high level", irq, 0);
        wr(4'hA, 8'h0D);
        idle(4);
        check("R11 switch src5", irq, 0);
    endtask

    task automatic t_clk_and_spare;
        wr(4'hA, 8'hF7);
        check("R2 clk_sel 11", clk_sel, 3);
        wr(4'hA, 8'h17);
        check("R2 clk_sel 01", clk_sel, 1);
        wr(4'hA, 8'hE7);
        check("R2 clk_sel 10 spare bits", clk_sel, 2);
        wr(4'hB, 8'h00); wr(4'h3, 8'h30); wr(4'hF, 8'hFF);
        check("R12 other offsets keep clk_sel", clk_sel, 2);
        check("R12 other offsets keep irq", irq, 0);
        // spare bits must not disturb a live source
        g0_portc[0] = 1'b0;
        wr(4'hA, 8'hC8); idle(4); wr(4'h9, 0);
        g0_portc[0] = 1'b1; idle(3);
        check("R2 spare bits ignored", irq, 1);
        wr(4'h9, 0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        g0_portc = '0; g1_portc = '0; timer_out = 1'b0;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        for (int s = 0; s < 6; s++) t_source(s);
        t_polarity();
        t_sync_latency();
        t_clear_race();
        t_soft();
        t_disabled();
        t_reseed();
        t_clk_and_spare();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #800000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule